// File: doc/BRIEF.md
# Field-Synchronized Packet Insertion Scheduler

This block follows a chain of packets kept in memory. It releases the payload of each packet onto a byte stream at a video field and screen line that the packet selects. A packet starts with an 8-byte header made of two little-endian 32-bit words. The first word points to the next packet and the second is a control word. The payload bytes follow the header in memory. The block fetches words through a single request/valid read port. It tracks field starts and lines from VSYNC, HSYNC and a 3-bit field-ID input. When a packet's conditions are met, it streams the payload out on a byte-wide valid/ready interface and can pulse an interrupt at the end of the packet.

Software writes the chain into memory and pulses `start` with the address of the first header. `busy` stays high until the packet whose next pointer is zero has been fully sent. All packet addresses must be multiples of four.

Top module: `pkt_field_sched`

## Requirements
- R1: After `start`, the first two memory requests read the header words at the head address and at the head address plus 4. Each request is high for exactly one cycle, and a new request is issued only after the previous one has been answered.
- R2: A next-pointer word of zero ends the walk. `busy` falls once the payload of that last packet has been sent, and no memory request is made while `busy` is low.
- R3: Control bits 12:0 give the payload length N. Exactly N bytes are sent, in ascending byte-address order starting at header address plus 8, with byte k of each word taken from data bits 8k+7:8k. When N is 0, the payload is skipped and no payload word is read.
- R4: When control bit 14 is 1, no payload byte of the packet is released before a VSYNC rising edge that comes after the header has been read and at which the field-ID input equals control bits 30:28.
- R5: When control bit 14 is 0, the packet does not wait for a field. If several packets follow one another and only the first has bit 14 set, they all go out in the same field. If every packet has bit 14 set, each goes out one field after the previous one.
- R6: The line count is 0 from a VSYNC rising edge and rises by one on each HSYNC rising edge. The first payload byte is released only while this count equals control bits 27:16.
- R7: A line value of 0xFFF in bits 27:16 turns off the line comparison, so the packet goes out in whatever line is current.
- R8: When control bit 15 is 1, `pkt_irq` pulses high for one cycle after the last byte of the packet, or after the packet's gate opens if it has no payload. When bit 15 is 0, no pulse is given.
- R9: Control bits 13 and 31 have no effect on the traffic.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R11: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a walk of the chain (one cycle) |
| head_ptr | input | AW | Byte address of the first header |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Read request, one-cycle pulse |
| mem_addr | output | AW | Byte address of the 32-bit word to read |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data word |
| vsync | input | 1 | Vertical sync, a rising edge starts a field |
| hsync | input | 1 | Horizontal sync, a rising edge advances the line |
| field_id | input | 3 | ID of the field, sampled on the VSYNC rising edge |
| out_valid | output | 1 | Payload byte is valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Sink accepts the byte |
| pkt_irq | output | 1 | End-of-packet interrupt pulse |

## Verification
The assertions are checked on every cycle. They cover the one-cycle request pulses, the absence of requests while idle, payload held steady under backpressure, single-cycle interrupts, the line count being 0 at each field start, and the line comparison at the moment the gate opens. Other behaviour can only be shown by the bench's scenarios, because each depends on a whole sequence of events. These are the byte order and count across word boundaries, the field in which a field-waiting packet actually appears, the slip by one field when every packet of a chain waits, skipped empty payloads, ignored control bits, and a `start` that arrives while busy.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int CNT_W  = 13;
  localparam int LINE_W = 12;
  localparam int FID_W  = 3;
  localparam logic [LINE_W-1:0] LINE_ANY = {LINE_W{1'b1}};

  typedef struct packed {
    logic [FID_W-1:0]  fid;
    logic [LINE_W-1:0] line;
    logic              irq_en;
    logic              want_fid;
    logic [CNT_W-1:0]  len;
  } ctrl_t;

  typedef enum logic [3:0] {
    T_IDLE, T_RQ0, T_W0, T_RQ1, T_W1, T_FIELD, T_LINE, T_PAY
  } walk_st_t;

  function automatic ctrl_t ctrl_decode(input logic [31:0] w);
    ctrl_t c;
    c.len      = w[12:0];
    c.want_fid = w[14];
    c.irq_en   = w[15];
    c.line     = w[27:16];
    c.fid      = w[30:28];
    return c;
  endfunction
endpackage

// File: rtl/pfs_timing.sv
module pfs_timing
  import pfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic              hsync,
  input  logic [FID_W-1:0]  field_id,
  output logic              field_start,
  output logic [FID_W-1:0]  start_fid,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [LINE_W-1:0] LINE_TOP = LINE_ANY - 1'b1;

  logic vs_q, hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q        <= 1'b0;
      hs_q        <= 1'b0;
      field_start <= 1'b0;
      start_fid   <= '0;
      line_cnt    <= '0;
    end else begin
      vs_q        <= vsync;
      hs_q        <= hsync;
      field_start <= 1'b0;
      if (vsync && !vs_q) begin
        field_start <= 1'b1;
        start_fid   <= field_id;
        line_cnt    <= '0;
      end else if (hsync && !hs_q && line_cnt != LINE_TOP) begin
        line_cnt <= line_cnt + 1'b1;
      end
    end
  end

  // R6
  line_zero_at_field_chk: assert property (@(posedge clk) disable iff (rst)
    field_start |-> line_cnt == '0);
endmodule

// File: rtl/pfs_streamer.sv
module pfs_streamer #(
  parameter int AW = 16,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  output logic          req,
  output logic [AW-1:0] addr,
  input  logic          rvalid,
  input  logic [31:0]   rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_EMIT} st_t;

  st_t           st;
  logic [CW-1:0] left;
  logic [1:0]    lane;
  logic [31:0]   wbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      req       <= 1'b0;
      addr      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      left      <= '0;
      lane      <= '0;
      wbuf      <= '0;
    end else begin
      req  <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          if (count == '0) begin
            done <= 1'b1;
          end else begin
            left <= count;
            addr <= base;
            st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          req <= 1'b1;
          st  <= S_WAIT;
        end
        S_WAIT: if (rvalid) begin
          wbuf      <= rdata;
          out_data  <= rdata[7:0];
          lane      <= '0;
          out_valid <= 1'b1;
          st        <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          if (left == 1) begin
            out_valid <= 1'b0;
            done      <= 1'b1;
            st        <= S_IDLE;
          end else begin
            left <= left - 1'b1;
            if (lane == 2'd3) begin
              out_valid <= 1'b0;
              addr      <= addr + 4;
              st        <= S_FETCH;
            end else begin
              lane     <= lane + 1'b1;
              out_data <= wbuf[{lane + 2'd1, 3'b000} +: 8];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R3
  no_byte_past_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> left != '0);
endmodule

// File: rtl/pkt_field_sched.sv
module pkt_field_sched
  import pfs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     head_ptr,
  output logic              busy,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              vsync,
  input  logic              hsync,
  input  logic [FID_W-1:0]  field_id,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              pkt_irq
);
  localparam int HDR_BYTES = 8;

  walk_st_t          st;
  logic [AW-1:0]     ptr;
  logic [31:0]       nxt_word;
  logic [31:0]       ctrl_word;
  ctrl_t             ctrl;
  logic              f_req;
  logic [AW-1:0]     f_addr;
  logic              go;
  logic              s_req, s_done;
  logic [AW-1:0]     s_addr;
  logic              field_start;
  logic [FID_W-1:0]  start_fid;
  logic [LINE_W-1:0] line_cnt;
  logic              ctrl_unused;

  assign ctrl        = ctrl_decode(ctrl_word);
  assign ctrl_unused = ctrl_word[13] ^ ctrl_word[31];
  assign busy        = (st != T_IDLE);
  assign mem_req     = f_req | s_req;
  assign mem_addr    = f_req ? f_addr : s_addr;

  pfs_timing u_timing (
    .clk(clk), .rst(rst), .vsync(vsync), .hsync(hsync), .field_id(field_id),
    .field_start(field_start), .start_fid(start_fid), .line_cnt(line_cnt)
  );

  pfs_streamer #(.AW(AW), .CW(CNT_W)) u_stream (
    .clk(clk), .rst(rst), .go(go), .base(ptr + AW'(HDR_BYTES)), .count(ctrl.len),
    .req(s_req), .addr(s_addr), .rvalid(mem_rvalid), .rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(s_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      ptr       <= '0;
      nxt_word  <= '0;
      ctrl_word <= '0;
      f_req     <= 1'b0;
      f_addr    <= '0;
      go        <= 1'b0;
      pkt_irq   <= 1'b0;
    end else begin
      f_req   <= 1'b0;
      go      <= 1'b0;
      pkt_irq <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          ptr <= head_ptr;
          st  <= T_RQ0;
        end
        T_RQ0: begin
          f_req  <= 1'b1;
          f_addr <= ptr;
          st     <= T_W0;
        end
        T_W0: if (mem_rvalid) begin
          nxt_word <= mem_rdata;
          st       <= T_RQ1;
        end
        T_RQ1: begin
          f_req  <= 1'b1;
          f_addr <= ptr + 4;
          st     <= T_W1;
        end
        T_W1: if (mem_rvalid) begin
          ctrl_word <= mem_rdata;
          st        <= mem_rdata[14] ? T_FIELD : T_LINE;
        end
        T_FIELD: if (field_start && start_fid == ctrl.fid) begin
          st <= T_LINE;
        end
        T_LINE: if (ctrl.line == LINE_ANY || line_cnt == ctrl.line) begin
          go <= 1'b1;
          st <= T_PAY;
        end
        T_PAY: if (s_done) begin
          pkt_irq <= ctrl.irq_en;
          if (nxt_word == '0) begin
            st <= T_IDLE;
          end else begin
            ptr <= nxt_word[AW-1:0];
            st  <= T_RQ0;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R2
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_irq |=> !pkt_irq);
  // R6
  line_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == T_PAY && $past(st) == T_LINE) |->
      (ctrl.line == LINE_ANY || $past(line_cnt) == ctrl.line));
  // R3
  idle_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !out_valid);
endmodule

// File: tb/tb_pkt_field_sched.sv
module tb_pkt_field_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] head_ptr = '0;
  logic        busy, mem_req, mem_rvalid, out_valid, out_ready, pkt_irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        vsync = 1'b0, hsync = 1'b0;
  logic [2:0]  field_id = '0;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  pkt_field_sched #(.AW(16)) dut (
    .clk(clk), .rst(rst), .start(start), .head_ptr(head_ptr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .vsync(vsync), .hsync(hsync), .field_id(field_id),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .pkt_irq(pkt_irq)
  );

  logic [31:0] mem [0:255];
  logic        p1 = 1'b0;
  logic [15:0] a1 = '0;
  always @(posedge clk) begin
    p1         <= mem_req;
    a1         <= mem_addr;
    mem_rvalid <= p1;
    mem_rdata  <= mem[a1[9:2]];
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // timing generator: field = 2 cycles VSYNC + 8 lines of 40 cycles
  bit fid_const = 0;
  int gen_field = 0;
  initial begin
    repeat (3) @(negedge clk);
    forever begin
      gen_field++;
      field_id = fid_const ? 3'd2 : 3'(gen_field);
      @(negedge clk) vsync = 1'b1;
      repeat (2) @(negedge clk);
      vsync = 1'b0;
      for (int l = 0; l < 8; l++) begin
        repeat (38) @(negedge clk);
        hsync = 1'b1;
        repeat (2) @(negedge clk);
        hsync = 1'b0;
      end
    end
  end

  int rdy_mode = 0, cyc = 0;
  always @(negedge clk) begin
    cyc++;
    out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // monitor with independent field/line model
  logic [7:0] lg [0:63];
  int lf [0:63];
  int ll [0:63];
  int n = 0, irqs = 0, nreq = 0, idle_req = 0, stall_bad = 0;
  int ra [0:15];
  int fcount = 0, lcnt = 0;
  bit vprev = 0, hprev = 0, stall_pend = 0;
  logic [7:0] stall_data = '0;
  always @(posedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && n < 64) begin
        lg[n] = out_data; lf[n] = fcount; ll[n] = lcnt; n++;
      end
      if (pkt_irq) irqs++;
      if (mem_req) begin
        if (nreq < 16) ra[nreq] = int'(mem_addr);
        nreq++;
        if (!busy) idle_req++;
      end
      if (stall_pend && !(out_valid && out_data == stall_data)) stall_bad++;
      stall_pend = out_valid && !out_ready;
      stall_data = out_data;
      if (vsync && !vprev) begin fcount++; lcnt = 0; end
      else if (hsync && !hprev) lcnt++;
      vprev = vsync; hprev = hsync;
    end
  end

  // expected payload
  logic [7:0] ex [0:63];
  int ne = 0;
  function automatic logic [31:0] mk_ctrl(int len, bit w, bit irq, int line, int fid);
    return {1'b0, 3'(fid), 12'(line), irq, w, 1'b0, 13'(len)};
  endfunction
  task automatic put_pkt(int a, int nxt, logic [31:0] c, int len, int seed);
    mem[a >> 2]       = 32'(nxt);
    mem[(a >> 2) + 1] = c;
    for (int i = 0; i < len; i++) begin
      int b = a + 8 + i;
      logic [7:0] v = 8'(seed + i * 7);
      mem[b >> 2][(b & 3) * 8 +: 8] = v;
      if (ne < 64) begin ex[ne] = v; ne++; end
    end
  endtask
  task automatic clr();
    n = 0; irqs = 0; nreq = 0; ne = 0;
  endtask
  task automatic wait_field();
    int f = fcount;
    while (fcount == f) @(negedge clk);
  endtask
  task automatic launch(int h);
    @(negedge clk); start = 1'b1; head_ptr = 16'(h);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  function automatic int bad_bytes();
    int b = 0;
    for (int i = 0; i < ne; i++) if (i >= n || lg[i] != ex[i]) b++;
    return b;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R2 reset busy", busy, 0);
    chk(out_valid == 0, "R3 reset out_valid", out_valid, 0);
    chk(pkt_irq == 0, "R8 reset irq", pkt_irq, 0);
    chk(mem_req == 0, "R1 reset mem_req", mem_req, 0);

    // sweep over target line and payload length (R3 R6 R8 R10)
    for (int L = 0; L < 8; L++) begin
      int fs;
      clr();
      rdy_mode = L % 2;
      put_pkt(16'h40, 0, mk_ctrl(L + 1, 0, L[0], L, 0), L + 1, L * 16);
      wait_field();
      fs = fcount;
      launch(16'h40);
      chk(n == L + 1, "R3 byte count", n, L + 1);
      chk(bad_bytes() == 0, "R3 byte order", bad_bytes(), 0);
      chk(ll[0] == L && lf[0] == fs, "R6 release line", ll[0], L);
      chk(irqs == (L % 2), "R8 irq enable", irqs, L % 2);
    end
    rdy_mode = 0;

    // line compare disabled (R7)
    begin
      int fs;
      clr();
      put_pkt(16'h40, 0, mk_ctrl(3, 0, 0, 12'hFFF, 0), 3, 5);
      wait_field();
      while (lcnt != 3) @(negedge clk);
      fs = fcount;
      launch(16'h40);
      chk(lf[0] == fs && ll[0] == 3, "R7 line any", ll[0], 3);
    end

    // chain with empty payload and ignored bits (R1 R2 R3 R8 R9)
    clr();
    put_pkt(16'h100, 16'h140, mk_ctrl(0, 0, 1, 12'hFFF, 0), 0, 0);
    put_pkt(16'h140, 16'h180, mk_ctrl(4, 0, 1, 12'hFFF, 0) | 32'h8000_2000, 4, 40);
    put_pkt(16'h180, 0, mk_ctrl(6, 0, 1, 12'hFFF, 0), 6, 90);
    launch(16'h100);
    chk(n == 10, "R3 chain bytes", n, 10);
    chk(bad_bytes() == 0, "R9 ignored bits", bad_bytes(), 0);
    chk(irqs == 3, "R8 chain irqs", irqs, 3);
    chk(ra[0] == 16'h100 && ra[1] == 16'h104, "R1 header reads", ra[1], 16'h104);
    chk(ra[2] == 16'h140, "R3 empty skips payload", ra[2], 16'h140);
    chk(busy == 0, "R2 end of chain", busy, 0);

    // field wait, counting field IDs (R4)
    begin
      int fs, tgt;
      clr();
      wait_field();
      tgt = (int'(field_id) + 3) % 8;
      put_pkt(16'h40, 0, mk_ctrl(2, 1, 0, 2, tgt), 2, 7);
      fs = fcount;
      launch(16'h40);
      chk(n == 2, "R4 bytes", n, 2);
      chk(lf[0] == fs + 3, "R4 field", lf[0], fs + 3);
      chk(ll[0] == 2, "R4 line", ll[0], 2);
    end

    // constant field ID: all wait vs first waits (R5)
    fid_const = 1;
    wait_field(); wait_field();
    begin
      int fs;
      clr();
      put_pkt(16'h100, 16'h140, mk_ctrl(2, 1, 0, 12'hFFF, 2), 2, 11);
      put_pkt(16'h140, 0, mk_ctrl(2, 1, 0, 12'hFFF, 2), 2, 22);
      wait_field();
      fs = fcount;
      launch(16'h100);
      chk(lf[0] == fs + 1, "R5 first field", lf[0], fs + 1);
      chk(lf[2] == lf[0] + 1, "R5 all wait slips", lf[2], lf[0] + 1);
      clr();
      put_pkt(16'h100, 16'h140, mk_ctrl(2, 1, 0, 12'hFFF, 2), 2, 11);
      put_pkt(16'h140, 0, mk_ctrl(2, 0, 0, 12'hFFF, 2), 2, 22);
      wait_field();
      launch(16'h100);
      chk(lf[2] == lf[0], "R5 same field", lf[2], lf[0]);
    end

    // start while busy (R11)
    clr();
    put_pkt(16'h240, 0, mk_ctrl(5, 0, 0, 12'hFFF, 0), 5, 200);
    clr();
    put_pkt(16'h200, 0, mk_ctrl(3, 1, 0, 12'hFFF, 2), 3, 60);
    @(negedge clk); start = 1'b1; head_ptr = 16'h200;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; head_ptr = 16'h240;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(n == 3, "R11 busy start ignored", n, 3);
    chk(bad_bytes() == 0, "R11 bytes", bad_bytes(), 0);

    chk(stall_bad == 0, "R10 stall hold", stall_bad, 0);
    chk(idle_req == 0, "R2 idle requests", idle_req, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule